// File: doc/BRIEF.md
# Floating-point status exception accumulator

This block holds the 32-bit floating-point status word of an execution unit. Each time an arithmetic operation retires, the unit presents a one-cycle event that carries the operation's raw exception flags. On that event the block ORs the flags into sticky status bits. It then folds the invalid-operation sub-causes into the invalid summary and rebuilds the enabled-exception summary from the enable bits. It reports in a one-cycle pulse whether the operation must trap.

Two side outputs go to the rest of the pipeline. If the instruction carries a record request, the block asks for condition-register field 1 to be written with the top nibble of the status word as it stood before the event. If the instruction wants its base address updated, the block grants that write-back only when no trap is raised. Software can overwrite the whole status word through a direct write port, and that port takes priority over a same-cycle event.

Top module: `fpstat_accum`

## Requirements
- R1: While rst_ni is low, stat_o, trap_o, cr_we_o, cr_field_o and upd_we_o are all zero.
- R2: On an accepted event (flags_valid_i=1, wr_en_i=0), a nonzero flags_i sets stat_o[31] (FX). A zero flags_i leaves FX unchanged.
- R3: The flags_i bit positions are: 0 overflow, 1 underflow, 2 divide-by-zero, 3 inexact, 4 invalid, 5 signalling NaN, 6 inf-inf, 7 inf/inf, 8 zero/zero, 9 inf*zero, 10 invalid compare, 11 software request, 12 invalid square root, 13 invalid integer convert. An accepted event ORs each flag into its status bit: 28, 27, 26, 25, 29, 24, 23, 22, 21, 20, 19, 10, 9 and 8 respectively. It never clears any of these bits, nor bit 31.
- R4: After an accepted event, stat_o[29] (VX) is 1 if any of bits 24..19 or 10..8 is 1.
- R5: After an accepted event, stat_o[30] (FEX) is recomputed from scratch. It is 1 exactly when any of the pairs (29,7), (28,6), (27,5), (26,4) or (25,3) has both bits set. trap_o pulses for one cycle in the cycle after the event and equals that FEX.
- R6: upd_we_o pulses in the cycle after an accepted event when upd_req_i was 1 and the event did not trap.
- R7: An accepted event with record_i=1 pulses cr_we_o in the next cycle. cr_field_o then carries stat_o[31:28] as it was before that event. With record_i=0, cr_we_o stays 0.
- R8: wr_en_i=1 loads wr_data_i unchanged into stat_o in the next cycle. If flags_valid_i is also 1 in that cycle, the event is dropped: trap_o, cr_we_o and upd_we_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flags_valid_i | input | 1 | Operation retire event |
| flags_i | input | 14 | Raw exception flags of the operation |
| record_i | input | 1 | Instruction requests a condition-field copy |
| upd_req_i | input | 1 | Instruction requests a base-address write-back |
| wr_en_i | input | 1 | Direct write of the status word |
| wr_data_i | input | 32 | Value for the direct write |
| stat_o | output | 32 | Status word |
| trap_o | output | 1 | Enabled exception, trap required |
| cr_we_o | output | 1 | Write strobe for condition field 1 |
| cr_field_o | output | 4 | Value for condition field 1 |
| upd_we_o | output | 1 | Base-address write-back grant |

## Verification
A wrong status bit shows on stat_o one cycle after the event that corrupts it. A wrong bit that lies in the top nibble also shows on cr_field_o at the next recorded event. A stale or leftover enabled-exception summary shows as a wrong trap_o pulse in the same cycle, together with a wrong upd_we_o grant. The vectors preload status words whose summary bits disagree with their causes and enables. This exposes merge logic that only ORs instead of rebuilding FEX, and a condition copy taken after the merge.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;
  localparam int unsigned STAT_W = 32;
  localparam int unsigned NFLAG  = 14;
  localparam int unsigned NENA   = 5;

  localparam int unsigned FX_B  = 31;
  localparam int unsigned FEX_B = 30;
  localparam int unsigned VX_B  = 29;
  localparam int unsigned ENA_LO = 3;   // XE..VE at 3..7
  localparam int unsigned EXC_LO = 25;  // XX..VX at 25..29

  localparam logic [STAT_W-1:0] VX_SUB_MASK = 32'h01F8_0700;
  localparam logic [STAT_W-1:0] STICKY_MASK = 32'hBFF8_0700;

  // status bit position for each incoming flag index
  function automatic int unsigned flag_pos(input int unsigned i);
    case (i)
      0: flag_pos = 28;
      1: flag_pos = 27;
      2: flag_pos = 26;
      3: flag_pos = 25;
      4: flag_pos = 29;
      11: flag_pos = 10;
      12: flag_pos = 9;
      13: flag_pos = 8;
      default: flag_pos = 29 - i; // 5..10 -> 24..19
    endcase
  endfunction
endpackage

// File: rtl/fpstat_merge.sv
module fpstat_merge
  import fpstat_pkg::*;
#(
  parameter int unsigned NF = NFLAG
) (
  input  logic [STAT_W-1:0] stat_i,
  input  logic [NF-1:0]     flags_i,
  output logic [STAT_W-1:0] merged_o
);
  logic [STAT_W-1:0] hit;

  always_comb begin
    hit = '0;
    for (int unsigned i = 0; i < NF; i++) begin
      hit[flag_pos(i)] = hit[flag_pos(i)] | flags_i[i];
    end
    hit[FX_B] = |flags_i;
  end

  always_comb begin
    merged_o = stat_i | hit;
    if (|(merged_o & VX_SUB_MASK)) merged_o[VX_B] = 1'b1;
  end
endmodule

// File: rtl/fpstat_summary.sv
module fpstat_summary
  import fpstat_pkg::*;
#(
  parameter int unsigned NE = NENA
) (
  input  logic [STAT_W-1:0] stat_i,
  output logic              fex_o
);
  logic [NE-1:0] exc, ena;

  assign exc   = stat_i[EXC_LO +: NE];
  assign ena   = stat_i[ENA_LO +: NE];
  assign fex_o = |(exc & ena);
endmodule

// File: rtl/fpstat_accum.sv
module fpstat_accum
  import fpstat_pkg::*;
#(
  parameter int unsigned NF = NFLAG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flags_valid_i,
  input  logic [NF-1:0]     flags_i,
  input  logic              record_i,
  input  logic              upd_req_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              trap_o,
  output logic              cr_we_o,
  output logic [3:0]        cr_field_o,
  output logic              upd_we_o
);
  logic [STAT_W-1:0] stat_q, merged;
  logic              fex_new, trap_q, cr_we_q, upd_we_q;
  logic [3:0]        cr_field_q;
  logic              evt;

  assign evt = flags_valid_i & ~wr_en_i;

  fpstat_merge #(.NF(NF)) u_merge (
    .stat_i   (stat_q),
    .flags_i  (flags_i),
    .merged_o (merged)
  );

  fpstat_summary #(.NE(NENA)) u_summary (
    .stat_i (merged),
    .fex_o  (fex_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q     <= '0;
      trap_q     <= 1'b0;
      cr_we_q    <= 1'b0;
      cr_field_q <= '0;
      upd_we_q   <= 1'b0;
    end else begin
      trap_q   <= 1'b0;
      cr_we_q  <= 1'b0;
      upd_we_q <= 1'b0;
      if (wr_en_i) begin
        stat_q <= wr_data_i;
      end else if (flags_valid_i) begin
        stat_q          <= merged;
        stat_q[FEX_B]   <= fex_new;
        trap_q          <= fex_new;
        cr_we_q         <= record_i;
        upd_we_q        <= upd_req_i & ~fex_new;
        // copy taken from the pre-merge value
        if (record_i) cr_field_q <= stat_q[STAT_W-1 -: 4];
      end
    end
  end

  assign stat_o     = stat_q;
  assign trap_o     = trap_q;
  assign cr_we_o    = cr_we_q;
  assign cr_field_o = cr_field_q;
  assign upd_we_o   = upd_we_q;

  a_r2_fx_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && flags_i != '0) |=> stat_q[FX_B]);
  a_r2_fx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && flags_i == '0) |=> stat_q[FX_B] == $past(stat_q[FX_B]));
  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> ((stat_q & $past(stat_q) & STICKY_MASK) == ($past(stat_q) & STICKY_MASK)));
  a_r4_vx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> (!(|(stat_q & VX_SUB_MASK)) || stat_q[VX_B]));
  a_r5_trap_fex: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> stat_q[FEX_B]);
  a_r6_no_upd_on_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_we_o |-> !trap_o);
  a_r8_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (stat_q == $past(wr_data_i)) && !trap_o && !cr_we_o && !upd_we_o);
endmodule

// File: tb/fpstat_accum_bench.sv
module fpstat_accum_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flags_valid_i = 1'b0;
  logic [13:0] flags_i = '0;
  logic        record_i = 1'b0;
  logic        upd_req_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] stat_o;
  logic        trap_o, cr_we_o, upd_we_o;
  logic [3:0]  cr_field_o;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  fpstat_accum u_fpstat_accum (.*);

  // {record, upd_req, flags[13:0], preload[31:0]}
  localparam int NV = 10;
  localparam logic [47:0] VEC [NV] = '{
    {1'b0, 1'b0, 14'h0000, 32'h0000_0000},
    {1'b0, 1'b0, 14'h0020, 32'h0000_0080},
    {1'b0, 1'b1, 14'h0001, 32'h0000_0040},
    {1'b0, 1'b0, 14'h3FFF, 32'h0000_0000},
    {1'b1, 1'b1, 14'h0008, 32'h0000_0008},
    {1'b1, 1'b1, 14'h0000, 32'h9000_0000},
    {1'b0, 1'b1, 14'h0002, 32'h4000_0000},
    {1'b0, 1'b0, 14'h0000, 32'h0400_0010},
    {1'b1, 1'b0, 14'h0000, 32'h2000_0000},
    {1'b0, 1'b0, 14'h1000, 32'h0000_0020}
  };

  function automatic logic [31:0] ref_stat(input logic [31:0] s, input logic [13:0] f);
    logic [31:0] r = s;
    if (f != 0) r[31] = 1'b1;
    r[28] |= f[0]; r[27] |= f[1]; r[26] |= f[2]; r[25] |= f[3]; r[29] |= f[4];
    r[24] |= f[5]; r[23] |= f[6]; r[22] |= f[7]; r[21] |= f[8]; r[20] |= f[9];
    r[19] |= f[10]; r[10] |= f[11]; r[9] |= f[12]; r[8] |= f[13];
    if (r[24] | r[23] | r[22] | r[21] | r[20] | r[19] | r[10] | r[9] | r[8]) r[29] = 1'b1;
    r[30] = (r[29] & r[7]) | (r[28] & r[6]) | (r[27] & r[5]) | (r[26] & r[4]) | (r[25] & r[3]);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      finish_run();
    end
  end

  task automatic preload(input logic [31:0] v);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = v;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic event_pulse(input logic [13:0] f, input logic rec, input logic upd);
    flags_valid_i = 1'b1; flags_i = f; record_i = rec; upd_req_i = upd;
    @(negedge clk_i);
    flags_valid_i = 1'b0; flags_i = '0; record_i = 1'b0; upd_req_i = 1'b0;
  endtask

  initial begin
    // R1 reset state
    #35;
    chk("R1 stat", stat_o, 32'h0);
    chk("R1 trap", {31'b0, trap_o}, 32'h0);
    chk("R1 cr_we", {31'b0, cr_we_o}, 32'h0);
    chk("R1 cr_field", {28'b0, cr_field_o}, 32'h0);
    chk("R1 upd_we", {31'b0, upd_we_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [31:0] pre, exp;
      logic [13:0] f;
      logic rec, upd;
      {rec, upd, f, pre} = VEC[i];
      exp = ref_stat(pre, f);
      preload(pre);
      event_pulse(f, rec, upd);
      chk("R2 R3 R4 status", stat_o, exp);
      chk("R5 trap", {31'b0, trap_o}, {31'b0, exp[30]});
      chk("R6 upd_we", {31'b0, upd_we_o}, {31'b0, upd & ~exp[30]});
      chk("R7 cr_we", {31'b0, cr_we_o}, {31'b0, rec});
      if (rec) chk("R7 cr_field", {28'b0, cr_field_o}, {28'b0, pre[31:28]});
    end

    // R3 sticky: an event with no flags keeps previously set causes
    preload(32'h0000_0000);
    event_pulse(14'h0004, 1'b0, 1'b0);
    event_pulse(14'h0000, 1'b0, 1'b0);
    chk("R3 sticky zx", stat_o, 32'h8400_0000);

    // R8 direct write loads unchanged, including inconsistent summaries
    preload(32'hDEAD_BEEF);
    chk("R8 write", stat_o, 32'hDEAD_BEEF);

    // R8 write wins over a same-cycle event
    preload(32'h0000_00F8);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = 32'h0000_0080;
    flags_valid_i = 1'b1; flags_i = 14'h3FFF; record_i = 1'b1; upd_req_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; flags_valid_i = 1'b0; flags_i = '0; record_i = 1'b0; upd_req_i = 1'b0;
    chk("R8 collide stat", stat_o, 32'h0000_0080);
    chk("R8 collide trap", {31'b0, trap_o}, 32'h0);
    chk("R8 collide cr_we", {31'b0, cr_we_o}, 32'h0);
    chk("R8 collide upd", {31'b0, upd_we_o}, 32'h0);

    // R5 trap is a single-cycle pulse
    preload(32'h0000_0040);
    event_pulse(14'h0001, 1'b0, 1'b0);
    chk("R5 trap pulse", {31'b0, trap_o}, 32'h1);
    @(negedge clk_i);
    chk("R5 trap drop", {31'b0, trap_o}, 32'h0);

    // R1 asynchronous reset mid-run
    rst_ni = 1'b0;
    #3;
    chk("R1 async clear", stat_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    finish_run();
  end
endmodule